// File: doc/BRIEF.md
# Dual-Modulus Divider and Phase-Frequency Detector

This block is the digital divide-and-compare path of an integer-N frequency synthesizer. It runs on one system clock. The divided reference input and the output of an external divide-by-10/11 prescaler reach it as single-cycle strobes, `ref_tick` and `pre_tick`.

A reference counter divides the reference strobes. A main counter and a swallow counter divide the prescaler strobes and drive `mod_sel`, which tells the prescaler to divide by 11 or by 10. Over one main cycle the voltage-controlled oscillator is therefore divided by 10·(M+1)+A.

The two divided strobes feed a phase-frequency detector with active-low up and down outputs. A lock flag is raised once the detector has stayed balanced through a programmable number of comparison cycles.

A 20-bit configuration word holds R, M and A. Writing it never shortens a division cycle that is already running: each counter takes its new value only at its own terminal count.

Top module: `pll_divider_pfd`

## Requirements
- R1: After reset, `up_n` and `dn_n` are 1, and `locked`, `mod_sel`, `r_div` and `m_div` are 0.
- R2: The reference path emits one `r_div` strobe for every R+1 `ref_tick` strobes. The strobe appears in the cycle after the terminal `ref_tick`. R is `cfg_word[19:14]`.
- R3: The feedback path emits one `m_div` strobe for every M+1 `pre_tick` strobes. The strobe appears in the cycle after the terminal `pre_tick`. M is `cfg_word[13:4]`.
- R4: Within each main cycle, `mod_sel` is 1 (divide by 11) for the first A prescaler periods and 0 (divide by 10) for the rest. It changes only on a `pre_tick`. This gives a total division of 10·(M+1)+A for any A from 0 to M. A is `cfg_word[3:0]`.
- R5: A word written with `cfg_wr` takes effect in each counter only at that counter's next terminal count. The first tick after reset is itself a terminal count.
- R6: `up_n` goes low in the cycle after `r_div`, and `dn_n` goes low in the cycle after `m_div`. Each stays low until the other side arrives.
- R7: When `up_n` and `dn_n` are both low, both return high on the next clock, unless a new divided strobe is present in that same cycle.
- R8: A lock counter counts `r_div` strobes while `up_n` equals `dn_n` and clears when they differ. `locked` is 1 when that counter is nonzero and has reached `lock_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One strobe per reference period |
| pre_tick | input | 1 | One strobe per prescaler output period |
| cfg_wr | input | 1 | Loads `cfg_word` into the holding register |
| cfg_word | input | RW+MW+AW (20) | {R, M, A} |
| lock_thresh | input | LW (8) | Balanced comparison cycles required before lock |
| mod_sel | output | 1 | 1 = prescaler divides by 11, 0 = by 10 |
| r_div | output | 1 | Divided reference strobe |
| m_div | output | 1 | Divided feedback strobe |
| up_n | output | 1 | Detector up output, active low |
| dn_n | output | 1 | Detector down output, active low |
| locked | output | 1 | Lock indication |

## Verification
The bench sums 11 or 10 for every prescaler period across whole main cycles. A swallow counter that is off by one period therefore shows up as a total of 10·(M+1)+A±1. The case A=M tests the point where the swallow count runs out one period before the main count.

A configuration is written in the middle of a cycle to check R5. A design that reloads at once would cut the running cycle short instead of finishing the old length.

Each detector ordering is exercised: reference first, feedback first, and both in the same cycle. A design that never clears the coincident state would hold both outputs low forever. The bench then forces a one-sided error after lock. An unlock path that ignores the mismatch would keep `locked` high.

// File: rtl/pll_divider_pfd.sv
module pll_divider_pfd #(
  parameter int RW = 6,
  parameter int MW = 10,
  parameter int AW = 4,
  parameter int LW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref_tick,
  input  logic                   pre_tick,
  input  logic                   cfg_wr,
  input  logic [RW+MW+AW-1:0]    cfg_word,
  input  logic [LW-1:0]          lock_thresh,
  output logic                   mod_sel,
  output logic                   r_div,
  output logic                   m_div,
  output logic                   up_n,
  output logic                   dn_n,
  output logic                   locked
);
  localparam logic [LW-1:0] LK_MAX = '1;

  logic [RW-1:0] r_sh, r_cnt;
  logic [MW-1:0] m_sh, m_cnt;
  logic [AW-1:0] a_sh, a_cnt;
  logic          up_q, dn_q;
  logic [LW-1:0] lk_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {r_sh, m_sh, a_sh} <= '0;
    else if (cfg_wr) {r_sh, m_sh, a_sh} <= cfg_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_cnt <= '0;
      r_div <= 1'b0;
    end else begin
      r_div <= ref_tick && (r_cnt == '0);
      if (ref_tick) r_cnt <= (r_cnt == '0) ? r_sh : r_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_cnt <= '0;
      a_cnt <= '0;
      m_div <= 1'b0;
    end else begin
      m_div <= pre_tick && (m_cnt == '0);
      if (pre_tick) begin
        if (m_cnt == '0) begin
          m_cnt <= m_sh;
          a_cnt <= a_sh;
        end else begin
          m_cnt <= m_cnt - 1'b1;
          if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
        end
      end
    end

  assign mod_sel = (a_cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      up_q <= r_div;
      dn_q <= m_div;
    end else begin
      up_q <= up_q | r_div;
      dn_q <= dn_q | m_div;
    end

  assign up_n = ~up_q;
  assign dn_n = ~dn_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lk_cnt <= '0;
    else if (up_q ^ dn_q) lk_cnt <= '0;
    else if (r_div && lk_cnt != LK_MAX) lk_cnt <= lk_cnt + 1'b1;

  assign locked = (lk_cnt != '0) && (lk_cnt >= lock_thresh);
endmodule

// File: rtl/pll_divider_pfd_chk.sv
module pll_divider_pfd_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_tick,
  input logic          pre_tick,
  input logic [LW-1:0] lock_thresh,
  input logic          mod_sel,
  input logic          r_div,
  input logic          m_div,
  input logic          up_n,
  input logic          dn_n,
  input logic          locked
);
  a_r2_no_tick_no_rdiv: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> !r_div);

  a_r3_no_tick_no_mdiv: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tick |=> !m_div);

  a_r4_mod_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tick |=> $stable(mod_sel));

  a_r6_up_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
    r_div |=> !up_n);

  a_r6_dn_follows_fb: assert property (@(posedge clk) disable iff (!rst_n)
    m_div |=> !dn_n);

  a_r7_both_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n && !dn_n && !r_div && !m_div) |=> (up_n && dn_n));

  a_r8_unlock_on_skew: assert property (@(posedge clk) disable iff (!rst_n)
    (up_n != dn_n) |=> !locked);
endmodule

bind pll_divider_pfd pll_divider_pfd_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_tick(pre_tick),
  .lock_thresh(lock_thresh), .mod_sel(mod_sel), .r_div(r_div), .m_div(m_div),
  .up_n(up_n), .dn_n(dn_n), .locked(locked)
);

// File: tb/sim_pll_divider_pfd.sv
module sim_pll_divider_pfd;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, pre_tick = 1'b0, cfg_wr = 1'b0;
  logic [19:0] cfg_word = '0;
  logic [7:0]  lock_thresh = 8'd3;
  logic mod_sel, r_div, m_div, up_n, dn_n, locked;
  logic s_mod, s_r, s_m, s_up, s_dn, s_lk;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_divider_pfd u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rt, input bit pt);
    ref_tick = rt; pre_tick = pt;
    s_mod = mod_sel;
    @(posedge clk); @(negedge clk);
    ref_tick = 1'b0; pre_tick = 1'b0;
    s_r = r_div; s_m = m_div; s_up = up_n; s_dn = dn_n; s_lk = locked;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int r, input int m, input int a);
    cfg_word = {r[5:0], m[9:0], a[3:0]};
    cfg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic next_r(output int ticks);
    ticks = 0;
    for (int i = 0; i < 5000; i++) begin
      cyc(1'b1, 1'b0);
      ticks++;
      if (s_r) break;
    end
  endtask

  task automatic next_m(output int ticks, output int mods, output int vco);
    ticks = 0; mods = 0; vco = 0;
    for (int i = 0; i < 5000; i++) begin
      cyc(1'b0, 1'b1);
      ticks++;
      if (s_mod) mods++;
      vco += s_mod ? 11 : 10;
      if (s_m) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(up_n && dn_n, "R1 detector idle", {up_n, dn_n}, 3);
    chk(!locked && !mod_sel, "R1 lock/mod low", {locked, mod_sel}, 0);
    chk(!r_div && !m_div, "R1 strobes low", {r_div, m_div}, 0);
  endtask

  task automatic t_ref_div();
    int t;
    do_reset(); wr(4, 0, 0);
    next_r(t); chk(t == 1, "R5 first tick terminal", t, 1);
    for (int k = 0; k < 3; k++) begin
      next_r(t); chk(t == 5, "R2 ref divide R=4", t, 5);
    end
    wr(0, 0, 0);
    next_r(t); chk(t == 5, "R5 ref old length kept", t, 5);
    next_r(t); chk(t == 1, "R2 ref divide R=0", t, 1);
  endtask

  task automatic t_main_div(input int m, input int a);
    int t, md, v;
    do_reset(); wr(0, m, a);
    next_m(t, md, v);
    for (int k = 0; k < 2; k++) begin
      next_m(t, md, v);
      chk(t == m + 1, "R3 main divide", t, m + 1);
      chk(md == a, "R4 divide-by-11 periods", md, a);
      chk(v == 10 * (m + 1) + a, "R4 total division", v, 10 * (m + 1) + a);
    end
  endtask

  task automatic t_midcycle_load();
    int t, md, v;
    do_reset(); wr(0, 7, 3);
    next_m(t, md, v);
    next_m(t, md, v);
    cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
    wr(0, 2, 1);
    next_m(t, md, v);
    chk(t == 6, "R5 running cycle finishes", t, 6);
    next_m(t, md, v);
    chk(t == 3, "R5 new M applied", t, 3);
    chk(v == 31, "R5 new A applied", v, 31);
  endtask

  task automatic t_pfd(input bit ref_first);
    do_reset(); wr(0, 0, 0);
    cyc(ref_first, !ref_first);
    cyc(1'b0, 1'b0);
    if (ref_first) chk(!s_up && s_dn, "R6 up on ref lead", {s_up, s_dn}, 1);
    else           chk(s_up && !s_dn, "R6 dn on fb lead", {s_up, s_dn}, 2);
    repeat (3) cyc(1'b0, 1'b0);
    chk(s_up != s_dn, "R6 held until other edge", {s_up, s_dn}, ref_first ? 1 : 2);
    cyc(!ref_first, ref_first);
    cyc(1'b0, 1'b0);
    chk(!s_up && !s_dn, "R6 both active", {s_up, s_dn}, 0);
    cyc(1'b0, 1'b0);
    chk(s_up && s_dn, "R7 both released", {s_up, s_dn}, 3);
  endtask

  task automatic t_coincident();
    do_reset(); wr(0, 0, 0);
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b0);
    chk(!s_up && !s_dn, "R7 coincident both low", {s_up, s_dn}, 0);
    cyc(1'b0, 1'b0);
    chk(s_up && s_dn, "R7 coincident release", {s_up, s_dn}, 3);
  endtask

  task automatic t_lock();
    do_reset(); wr(0, 0, 0);
    lock_thresh = 8'd3;
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 1'b1);
      repeat (3) cyc(1'b0, 1'b0);
      chk(s_lk == (k >= 3), "R8 lock after threshold", s_lk, k >= 3);
    end
    cyc(1'b1, 1'b0);
    repeat (3) cyc(1'b0, 1'b0);
    chk(!s_lk, "R8 unlock on one-sided error", s_lk, 0);
    cyc(1'b0, 1'b1);
    repeat (3) cyc(1'b0, 1'b0);
    chk(!s_lk, "R8 count restarts", s_lk, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ref_div();
    t_main_div(7, 3);
    t_main_div(5, 0);
    t_main_div(3, 3);
    t_midcycle_load();
    t_pfd(1'b1);
    t_pfd(1'b0);
    t_coincident();
    t_lock();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule